// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor

This block is a purely combinational two's-complement adder/subtractor. The default width is 16 bits. It never waits for a carry to ripple across the word. The operands are split into groups of four bits. Inside each group every carry is formed directly from per-bit generate and propagate terms and the group's incoming carry. Each group also reduces its bits to one group generate and one group propagate. A second lookahead level turns those group terms and the initial carry into the carry entering every group and the carry leaving the word.

A single mode input picks the operation. In add mode the second operand passes unchanged and the initial carry is zero. In subtract mode every bit of the second operand is inverted and the initial carry is one, so the adder forms the two's-complement difference. The block returns three results:
- the result word,
- the carry out of the most significant bit,
- a signed overflow flag.

The width, the group size and the choice of second-level structure are parameters. Elaboration-time checks limit every lookahead gate to a fan-in of five.

Top module: `lookahead_addsub`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (`op_a` + `op_b`) modulo 2^16.
- R2: With `sub_mode` = 1, `result` equals (`op_a` − `op_b`) modulo 2^16, formed as `op_a` + ~`op_b` + 1.
- R3: With `sub_mode` = 0, `carry_out` is bit 16 of the unsigned 17-bit sum `op_a` + `op_b`.
- R4: With `sub_mode` = 1, `carry_out` is 1 exactly when `op_a` ≥ `op_b` taken as unsigned numbers, meaning no borrow occurred.
- R5: With `sub_mode` = 0, `overflow` is 1 exactly when both operands have the same sign bit (bit 15) and the sign bit of `result` differs from it.
- R6: With `sub_mode` = 1, `overflow` is 1 exactly when `op_a` and ~`op_b` have the same sign bit and the sign bit of `result` differs from that of `op_a`.
- R7: A carry generated in bit 0 reaches every 4-bit group boundary and the word's carry-out in the same evaluation. For example, 16'hFFFF + 16'h0001 gives `result` 16'h0000 with `carry_out` 1, and 16'h0FFF + 16'h0001 gives 16'h1000.
- R8: Subtracting zero returns `op_a` unchanged with `carry_out` 1 and `overflow` 0. Subtracting the most negative value 16'h8000 from 0 gives 16'h8000 with `overflow` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand (minuend in subtract mode) |
| op_b | input | 16 | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | 16 | Sum or difference, modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 (1 means no borrow when subtracting) |
| overflow | output | 1 | Two's-complement overflow of the signed result |

## Verification
Random operands drawn from a biased mix exercise both modes. The mix places all-zeros, all-ones, 16'h8000 and 16'h7FFF in either slot often enough to hit sign and carry boundaries that uniform values would rarely reach. Full-propagate chains such as 16'hFFFF + 1 and 16'h0FFF + 1 tell apart a correct second-level carry from one that stops at a group boundary or takes the wrong group propagate. Subtracting zero and subtracting 16'h8000 separate a correctly forced initial carry and operand inversion from an off-by-one or wrong-sign difference. The same cases also show whether the overflow flag uses the carry into the top bit and not some other carry.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // Largest AND/OR fan-in the flat lookahead equations may use.
   localparam int unsigned CLA_MAX_FANIN = 5;

   // Generate/propagate pair summarising a bit or a group of bits.
   typedef struct packed {
      logic gen;
      logic prop;
   } cla_pg_t;

endpackage

// File: rtl/cla_bit_stage.sv
// Operand conditioning plus per-bit generate, propagate and half-sum.
module cla_bit_stage #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         invert,
   output logic [W-1:0] bit_gen,
   output logic [W-1:0] bit_prop,
   output logic [W-1:0] half_sum
);

   if (W < 2) begin : g_bad_width
      $error("cla_bit_stage: W must be at least 2");
   end

   logic [W-1:0] opb_eff;

   // Subtraction inverts the second operand; the +1 comes in as carry-in.
   assign opb_eff = opb ^ {W{invert}};

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bit_gen[i]  = opa[i] & opb_eff[i];
      assign bit_prop[i] = opa[i] | opb_eff[i];
      assign half_sum[i] = opa[i] ^ opb_eff[i];
   end

endmodule

// File: rtl/cla_group.sv
// One lookahead group: flat carries, sum bits, group generate/propagate.
module cla_group #(
   parameter int unsigned GW = 4
) (
   input  logic [GW-1:0]    bit_gen,
   input  logic [GW-1:0]    bit_prop,
   input  logic [GW-1:0]    half_sum,
   input  logic             carry_in,
   output logic [GW-1:0]    sum,
   output cla_pkg::cla_pg_t grp_pg
);

   if (GW < 1 || GW + 1 > cla_pkg::CLA_MAX_FANIN) begin : g_bad_group
      $error("cla_group: group width breaks the fan-in limit");
   end

   logic [GW:0] carry;

   // Every carry is a flat sum of products of the bit terms and carry_in.
   always_comb begin
      logic acc;
      logic prod;
      carry[0] = carry_in;
      for (int j = 0; j < GW; j++) begin
         acc = 1'b0;
         for (int i = 0; i <= j; i++) begin
            prod = bit_gen[i];
            for (int k = i + 1; k <= j; k++) prod = prod & bit_prop[k];
            acc = acc | prod;
         end
         prod = carry_in;
         for (int k = 0; k <= j; k++) prod = prod & bit_prop[k];
         carry[j+1] = acc | prod;
      end
   end

   // Group terms: the same expansion without the incoming carry.
   always_comb begin
      logic acc;
      logic prod;
      acc = 1'b0;
      for (int i = 0; i < GW; i++) begin
         prod = bit_gen[i];
         for (int k = i + 1; k < GW; k++) prod = prod & bit_prop[k];
         acc = acc | prod;
      end
      grp_pg.gen = acc;
      prod = 1'b1;
      for (int k = 0; k < GW; k++) prod = prod & bit_prop[k];
      grp_pg.prop = prod;
   end

   assign sum = half_sum ^ carry[GW-1:0];

   // The flat carries must match the bitwise recurrence c(i+1) = g + p.c.
   always_comb begin
      if (!$isunknown({bit_gen, bit_prop, carry_in})) begin
         for (int i = 0; i < GW; i++) begin
            p_flat_matches_chain_r7: assert (carry[i+1] == (bit_gen[i] | (bit_prop[i] & carry[i])))
               else $error("p_flat_matches_chain_r7: carry %0d mismatch", i + 1);
         end
         p_group_carry_out_r7: assert (carry[GW] == (grp_pg.gen | (grp_pg.prop & carry_in)))
            else $error("p_group_carry_out_r7: group terms disagree with carry chain");
      end
   end

endmodule

// File: rtl/cla_lookahead.sv
// Second-level unit: group carries from group generate/propagate terms.
module cla_lookahead #(
   parameter int unsigned NG            = 4,
   parameter bit          TOP_LOOKAHEAD = 1'b1
) (
   input  cla_pkg::cla_pg_t [NG-1:0] grp_pg,
   input  logic                      carry_in,
   output logic [NG:0]               grp_carry
);

   if (NG < 1) begin : g_bad_count
      $error("cla_lookahead: at least one group required");
   end

   if (TOP_LOOKAHEAD) begin : g_flat
      if (NG + 1 > cla_pkg::CLA_MAX_FANIN) begin : g_bad_fanin
         $error("cla_lookahead: too many groups for one flat lookahead level");
      end

      always_comb begin
         logic acc;
         logic prod;
         grp_carry[0] = carry_in;
         for (int j = 0; j < NG; j++) begin
            acc = 1'b0;
            for (int i = 0; i <= j; i++) begin
               prod = grp_pg[i].gen;
               for (int k = i + 1; k <= j; k++) prod = prod & grp_pg[k].prop;
               acc = acc | prod;
            end
            prod = carry_in;
            for (int k = 0; k <= j; k++) prod = prod & grp_pg[k].prop;
            grp_carry[j+1] = acc | prod;
         end
      end

      always_comb begin
         if (!$isunknown({grp_pg, carry_in})) begin
            for (int k = 0; k < NG; k++) begin
               p_group_chain_r7: assert (grp_carry[k+1] ==
                                        (grp_pg[k].gen | (grp_pg[k].prop & grp_carry[k])))
                  else $error("p_group_chain_r7: group carry %0d mismatch", k + 1);
            end
         end
      end
   end else begin : g_chain
      assign grp_carry[0] = carry_in;
      for (genvar k = 0; k < NG; k++) begin : g_link
         assign grp_carry[k+1] = grp_pg[k].gen | (grp_pg[k].prop & grp_carry[k]);
      end
   end

endmodule

// File: rtl/lookahead_addsub.sv
// Two-level carry-lookahead adder/subtractor.
module lookahead_addsub #(
   parameter int unsigned WIDTH         = 16,
   parameter int unsigned GROUP_W       = 4,
   parameter bit          TOP_LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub_mode,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             overflow
);

   localparam int unsigned NG  = WIDTH / GROUP_W;
   localparam int unsigned MSB = WIDTH - 1;

   if (GROUP_W == 0 || WIDTH % GROUP_W != 0) begin : g_bad_split
      $error("lookahead_addsub: WIDTH must be a multiple of GROUP_W");
   end

   logic [WIDTH-1:0]          bit_gen;
   logic [WIDTH-1:0]          bit_prop;
   logic [WIDTH-1:0]          half_sum;
   cla_pkg::cla_pg_t [NG-1:0] grp_pg;
   logic [NG:0]               grp_carry;

   cla_bit_stage #(.W(WIDTH)) u_bits (
      .opa      (op_a),
      .opb      (op_b),
      .invert   (sub_mode),
      .bit_gen  (bit_gen),
      .bit_prop (bit_prop),
      .half_sum (half_sum)
   );

   for (genvar k = 0; k < NG; k++) begin : g_grp
      cla_group #(.GW(GROUP_W)) u_group (
         .bit_gen  (bit_gen [k*GROUP_W +: GROUP_W]),
         .bit_prop (bit_prop[k*GROUP_W +: GROUP_W]),
         .half_sum (half_sum[k*GROUP_W +: GROUP_W]),
         .carry_in (grp_carry[k]),
         .sum      (result  [k*GROUP_W +: GROUP_W]),
         .grp_pg   (grp_pg[k])
      );
   end

   // Initial carry is the subtract control: supplies the +1 of two's complement.
   cla_lookahead #(.NG(NG), .TOP_LOOKAHEAD(TOP_LOOKAHEAD)) u_top (
      .grp_pg    (grp_pg),
      .carry_in  (sub_mode),
      .grp_carry (grp_carry)
   );

   assign carry_out = grp_carry[NG];
   // Carry into the top bit is recovered as half_sum ^ result at that bit.
   assign overflow  = (half_sum[MSB] ^ result[MSB]) ^ carry_out;

   // Port-level checks against arithmetic on the operands.
   always_comb begin
      logic [WIDTH-1:0] b_eff;
      b_eff = sub_mode ? ~op_b : op_b;
      if (!$isunknown({op_a, op_b, sub_mode})) begin
         if (!sub_mode) begin
            p_add_sum_r1: assert ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b}))
               else $error("p_add_sum_r1: wrong sum");
         end else begin
            p_sub_diff_r2: assert (result == (op_a - op_b))
               else $error("p_sub_diff_r2: wrong difference");
            p_no_borrow_r4: assert (carry_out == (op_a >= op_b))
               else $error("p_no_borrow_r4: wrong borrow indication");
         end
         p_signed_overflow_r5: assert (overflow ==
                                      ((op_a[MSB] == b_eff[MSB]) && (result[MSB] != op_a[MSB])))
            else $error("p_signed_overflow_r5: overflow flag wrong");
      end
   end

endmodule

// File: tb/test_lookahead_addsub.sv
module test_lookahead_addsub;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic        sub_mode = 1'b0;
   logic [15:0] result;
   logic        carry_out;
   logic        overflow;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   lookahead_addsub i_lookahead_addsub (
      .op_a      (op_a),
      .op_b      (op_b),
      .sub_mode  (sub_mode),
      .result    (result),
      .carry_out (carry_out),
      .overflow  (overflow)
   );

   // Expected {overflow, carry_out, result} from the requirements.
   function automatic logic [17:0] model(input logic [15:0] a, input logic [15:0] b, input logic s);
      logic [15:0] be;
      logic [16:0] full;
      logic        v;
      be   = s ? ~b : b;
      full = {1'b0, a} + {1'b0, be} + {16'd0, s};
      v    = (a[15] == be[15]) && (full[15] != a[15]);
      return {v, full};
   endfunction

   function automatic logic [15:0] pick();
      case ($urandom % 8)
         0: return 16'h0000;
         1: return 16'hFFFF;
         2: return 16'h8000;
         3: return 16'h7FFF;
         default: return 16'($urandom);
      endcase
   endfunction

   task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s a=%h b=%h sub=%0b actual=%h expected=%h",
                  tag, op_a, op_b, sub_mode, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic s, input string extra);
      logic [17:0] e;
      @(posedge clk);
      op_a = a; op_b = b; sub_mode = s;
      @(negedge clk);
      e = model(a, b, s);
      check({extra, s ? "R2 result" : "R1 result"}, {1'b0, result}, {1'b0, e[15:0]});
      check({extra, s ? "R4 carry_out" : "R3 carry_out"}, {16'd0, carry_out}, {16'd0, e[16]});
      check({extra, s ? "R6 overflow" : "R5 overflow"}, {16'd0, overflow}, {16'd0, e[17]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_CA11));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // Reset state: zero inputs give all-zero outputs (R1).
      check("R1 reset result", {1'b0, result}, 17'd0);
      check("R3 reset carry_out", {16'd0, carry_out}, 17'd0);
      check("R5 reset overflow", {16'd0, overflow}, 17'd0);
      rst = 1'b0;

      // R7: carries crossing every group boundary.
      apply(16'hFFFF, 16'h0001, 1'b0, "R7 ");
      apply(16'h0FFF, 16'h0001, 1'b0, "R7 ");
      apply(16'h00FF, 16'h0001, 1'b0, "R7 ");
      apply(16'h000F, 16'h0001, 1'b0, "R7 ");
      apply(16'h7FFF, 16'h0001, 1'b0, "R7 ");
      apply(16'hFFFF, 16'hFFFF, 1'b0, "R7 ");
      apply(16'h8000, 16'h8000, 1'b0, "R7 ");
      // R8: subtraction corners.
      apply(16'h1234, 16'h0000, 1'b1, "R8 ");
      apply(16'h0000, 16'h0000, 1'b1, "R8 ");
      apply(16'h0000, 16'h8000, 1'b1, "R8 ");
      apply(16'h8000, 16'h0001, 1'b1, "R8 ");
      apply(16'h0000, 16'h0001, 1'b1, "R8 ");
      apply(16'h7FFF, 16'hFFFF, 1'b1, "R8 ");
      apply(16'hFFFF, 16'hFFFF, 1'b1, "R8 ");

      for (int n = 0; n < 4000; n++) begin
         apply(pick(), pick(), 1'($urandom), "");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule